// File: doc/BRIEF.md
# Prefix Immediate Operand Former

This decode-stage block produces the second operand of each instruction. A dedicated prefix instruction carries an 11-bit constant that the block holds in a K register. The prefix also arms a one-shot flag. The next accepted instruction then sees a 16-bit immediate built from K as the upper part and its own 5-bit field as the lower part. Without a pending prefix, the 5-bit field is a short immediate, zero- or sign-extended, or, for the logic class, the address of a register whose read data becomes the operand. A fourth class takes K alone as its operand.

The operand path is combinational from the presented instruction and the held prefix state. The prefix state changes only on a clock edge where an instruction is accepted or a flush occurs. A flush discards any pending prefix. The 2-bit mode output tells later stages which operand kind was formed. `DATA_W` must be at least 16.

Top module: `pfx_opnd_former`

## Requirements
- R1: After reset no prefix is pending and K is zero. An instruction of class 3 yields operand 0 in mode 3, and classes 0 to 2 take their unprefixed forms.
- R2: A prefix instruction has opcode `insn_i[15:11] == 5'b11011`. When it is accepted, K is loaded from `insn_i[10:0]`, the flag is armed, and `op_valid_o` stays low for that instruction.
- R3: With a prefix pending, class 0 (unsigned) and class 1 (signed) produce `{K, insn_i[4:0]}` zero-extended to `DATA_W`, in mode 2.
- R4: With no prefix pending, class 0 produces `insn_i[4:0]` zero-extended, in mode 1.
- R5: With no prefix pending, class 1 produces `insn_i[4:0]` sign-extended from bit 4, in mode 1.
- R6: Class 2 (logic) with no prefix pending drives `rf_raddr_o = insn_i[4:0]` and outputs `rf_rdata_i` in mode 0. With a prefix pending it produces the 16-bit immediate in mode 2.
- R7: Class 3 outputs K zero-extended in mode 3 when a prefix is pending, and zero in mode 3 when none is pending.
- R8: The prefix flag is cleared by exactly one accepted non-prefix instruction. Cycles with `insn_valid_i` low leave the flag and K unchanged.
- R9: `flush_i` clears the flag and K at the next edge and takes priority over a same-cycle instruction, including a prefix. `op_valid_o` is low while flush is high.
- R10: A prefix that follows a prefix replaces K. The newest value is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_i | input | 1 | Pipeline flush; discards any pending prefix |
| insn_valid_i | input | 1 | Instruction accepted this cycle |
| insn_i | input | INSN_W | Instruction word |
| op_class_i | input | 2 | 0 unsigned, 1 signed, 2 logic, 3 K-only |
| rf_rdata_i | input | DATA_W | Register-file read data for `rf_raddr_o` |
| rf_raddr_o | output | FIELD_W | Register address, the 5-bit field |
| operand_o | output | DATA_W | Selected second operand |
| op_mode_o | output | 2 | 0 register, 1 short imm, 2 wide imm, 3 K only |
| op_valid_o | output | 1 | Operand meaningful this cycle |

## Verification
The bench builds the block with `DATA_W = 32`. This selects the generate branch that pads the 16-bit immediate with zeros. It also leaves sixteen or more upper bits in which a wrong sign or zero extension would show. The defaults for the instruction, K and field widths are kept, so the prefix opcode and the field positions in the requirements apply directly.

// File: rtl/pfx_opnd_pkg.sv
package pfx_opnd_pkg;
  typedef enum logic [1:0] {
    CLS_UNS   = 2'd0,
    CLS_SGN   = 2'd1,
    CLS_LOGIC = 2'd2,
    CLS_KONLY = 2'd3
  } opcls_e;

  typedef enum logic [1:0] {
    MODE_REG   = 2'd0,
    MODE_SHORT = 2'd1,
    MODE_WIDE  = 2'd2,
    MODE_KONLY = 2'd3
  } opmode_e;
endpackage

// File: rtl/pfx_rst_sync.sv
module pfx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/pfx_state.sv
module pfx_state #(
  parameter int INSN_W = 16,
  parameter int OPC_W  = 5,
  parameter int K_W    = 11,
  parameter logic [OPC_W-1:0] PFX_OPC = 5'b11011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic              is_pfx_o,
  output logic              pfx_q,
  output logic [K_W-1:0]    k_q
);
  logic           pfx_d;
  logic [K_W-1:0] k_d;
  logic           upd_en;

  assign is_pfx_o = (insn_i[INSN_W-1 -: OPC_W] == PFX_OPC);
  assign upd_en   = flush_i | valid_i;

  // next-state process
  always_comb begin
    pfx_d = pfx_q;
    k_d   = k_q;
    if (flush_i) begin
      pfx_d = 1'b0;
      k_d   = '0;
    end else if (valid_i) begin
      if (is_pfx_o) begin
        pfx_d = 1'b1;
        k_d   = insn_i[K_W-1:0];
      end else begin
        pfx_d = 1'b0;
      end
    end
  end

  // register process with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q <= 1'b0;
      k_q   <= '0;
    end else if (upd_en) begin
      pfx_q <= pfx_d;
      k_q   <= k_d;
    end
  end

  assert_load_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && valid_i && is_pfx_o) |=> (pfx_q && (k_q == $past(insn_i[K_W-1:0]))));

  assert_one_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && valid_i && !is_pfx_o) |=> !pfx_q);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !valid_i) |=> ($stable(pfx_q) && $stable(k_q)));

  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!pfx_q && (k_q == '0)));
endmodule

// File: rtl/pfx_opnd_mux.sv
module pfx_opnd_mux
  import pfx_opnd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int K_W     = 11,
  parameter int FIELD_W = 5
) (
  input  logic               pfx_i,
  input  logic [K_W-1:0]     k_i,
  input  logic [FIELD_W-1:0] field_i,
  input  opcls_e             cls_i,
  input  logic [DATA_W-1:0]  rf_rdata_i,
  output logic [DATA_W-1:0]  operand_o,
  output opmode_e            mode_o
);
  localparam int WIDE_W = K_W + FIELD_W;

  logic [DATA_W-1:0] wide_ext;
  logic [DATA_W-1:0] short_zx;
  logic [DATA_W-1:0] short_sx;
  logic [DATA_W-1:0] k_ext;

  generate
    if (DATA_W > WIDE_W) begin : g_wide_pad
      assign wide_ext = {{(DATA_W-WIDE_W){1'b0}}, k_i, field_i};
    end else begin : g_wide_exact
      assign wide_ext = {k_i, field_i};
    end
  endgenerate

  assign short_zx = {{(DATA_W-FIELD_W){1'b0}}, field_i};
  assign short_sx = {{(DATA_W-FIELD_W){field_i[FIELD_W-1]}}, field_i};
  assign k_ext    = {{(DATA_W-K_W){1'b0}}, (pfx_i ? k_i : {K_W{1'b0}})};

  always_comb begin
    operand_o = short_zx;
    mode_o    = MODE_SHORT;
    unique case (cls_i)
      CLS_KONLY: begin
        operand_o = k_ext;
        mode_o    = MODE_KONLY;
      end
      CLS_LOGIC: begin
        if (pfx_i) begin
          operand_o = wide_ext;
          mode_o    = MODE_WIDE;
        end else begin
          operand_o = rf_rdata_i;
          mode_o    = MODE_REG;
        end
      end
      CLS_SGN: begin
        operand_o = pfx_i ? wide_ext : short_sx;
        mode_o    = pfx_i ? MODE_WIDE : MODE_SHORT;
      end
      default: begin
        operand_o = pfx_i ? wide_ext : short_zx;
        mode_o    = pfx_i ? MODE_WIDE : MODE_SHORT;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown(pfx_i) && !$isunknown(mode_o)) begin
      if (mode_o == MODE_WIDE)
        assert_wide_needs_pfx_R3: assert (pfx_i);
      if (mode_o == MODE_SHORT)
        assert_short_without_pfx_R4: assert (!pfx_i);
    end
  end
endmodule

// File: rtl/pfx_opnd_former.sv
module pfx_opnd_former
  import pfx_opnd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int INSN_W  = 16,
  parameter int OPC_W   = 5,
  parameter int FIELD_W = 5,
  parameter logic [OPC_W-1:0] PFX_OPC = 5'b11011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               insn_valid_i,
  input  logic [INSN_W-1:0]  insn_i,
  input  logic [1:0]         op_class_i,
  input  logic [DATA_W-1:0]  rf_rdata_i,
  output logic [FIELD_W-1:0] rf_raddr_o,
  output logic [DATA_W-1:0]  operand_o,
  output logic [1:0]         op_mode_o,
  output logic               op_valid_o
);
  localparam int K_W = INSN_W - OPC_W;

  logic           rst_n_sync;
  logic           is_pfx;
  logic           pfx_q;
  logic [K_W-1:0] k_q;
  opmode_e        mode;

  pfx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pfx_state #(
    .INSN_W  (INSN_W),
    .OPC_W   (OPC_W),
    .K_W     (K_W),
    .PFX_OPC (PFX_OPC)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .flush_i  (flush_i),
    .valid_i  (insn_valid_i),
    .insn_i   (insn_i),
    .is_pfx_o (is_pfx),
    .pfx_q    (pfx_q),
    .k_q      (k_q)
  );

  pfx_opnd_mux #(
    .DATA_W  (DATA_W),
    .K_W     (K_W),
    .FIELD_W (FIELD_W)
  ) u_mux (
    .pfx_i      (pfx_q),
    .k_i        (k_q),
    .field_i    (insn_i[FIELD_W-1:0]),
    .cls_i      (opcls_e'(op_class_i)),
    .rf_rdata_i (rf_rdata_i),
    .operand_o  (operand_o),
    .mode_o     (mode)
  );

  assign rf_raddr_o = insn_i[FIELD_W-1:0];
  assign op_mode_o  = mode;
  assign op_valid_o = insn_valid_i & ~flush_i & ~is_pfx;

  assert_pfx_no_operand_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (insn_valid_i && is_pfx) |-> !op_valid_o);

  assert_flush_masks_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    flush_i |-> !op_valid_o);
endmodule

// File: tb/tb_pfx_opnd_former.sv
module tb_pfx_opnd_former;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int NV = 21;

  // {req[58:55], valid[54], flush[53], cls[52:51], insn[50:35], e_opv[34], e_mode[33:32], e_op[31:0]}
  localparam logic [58:0] VEC [NV] = '{
    {4'd4,  1'b1, 1'b0, 2'd0, 16'h0013, 1'b1, 2'd1, 32'h0000_0013}, // R4 short zero-ext
    {4'd5,  1'b1, 1'b0, 2'd1, 16'h0013, 1'b1, 2'd1, 32'hFFFF_FFF3}, // R5 short sign-ext
    {4'd6,  1'b1, 1'b0, 2'd2, 16'h0007, 1'b1, 2'd0, 32'hA5A5_0007}, // R6 register operand
    {4'd1,  1'b1, 1'b0, 2'd3, 16'h0000, 1'b1, 2'd3, 32'h0000_0000}, // R1 K clear after reset
    {4'd2,  1'b1, 1'b0, 2'd0, 16'hDDA3, 1'b0, 2'd0, 32'h0},         // R2 prefix K=5A3
    {4'd3,  1'b1, 1'b0, 2'd0, 16'h0013, 1'b1, 2'd2, 32'h0000_B473}, // R3 wide unsigned
    {4'd8,  1'b1, 1'b0, 2'd0, 16'h0013, 1'b1, 2'd1, 32'h0000_0013}, // R8 flag consumed
    {4'd2,  1'b1, 1'b0, 2'd0, 16'hDFFF, 1'b0, 2'd0, 32'h0},         // R2 prefix K=7FF
    {4'd3,  1'b1, 1'b0, 2'd1, 16'h001F, 1'b1, 2'd2, 32'h0000_FFFF}, // R3 wide signed class zero-ext
    {4'd2,  1'b1, 1'b0, 2'd0, 16'hD801, 1'b0, 2'd0, 32'h0},         // R2 prefix K=001
    {4'd8,  1'b0, 1'b0, 2'd0, 16'h0013, 1'b0, 2'd0, 32'h0},         // R8 idle cycle
    {4'd6,  1'b1, 1'b0, 2'd2, 16'h0004, 1'b1, 2'd2, 32'h0000_0024}, // R6 logic prefixed
    {4'd10, 1'b1, 1'b0, 2'd0, 16'hD923, 1'b0, 2'd0, 32'h0},         // R10 prefix K=123
    {4'd10, 1'b1, 1'b0, 2'd0, 16'hDC56, 1'b0, 2'd0, 32'h0},         // R10 prefix K=456
    {4'd7,  1'b1, 1'b0, 2'd3, 16'h0000, 1'b1, 2'd3, 32'h0000_0456}, // R7 K only, newest K
    {4'd7,  1'b1, 1'b0, 2'd3, 16'h0000, 1'b1, 2'd3, 32'h0000_0000}, // R7 K only unprefixed
    {4'd2,  1'b1, 1'b0, 2'd0, 16'hD8AB, 1'b0, 2'd0, 32'h0},         // R2 prefix K=0AB
    {4'd9,  1'b1, 1'b1, 2'd0, 16'h0013, 1'b0, 2'd0, 32'h0},         // R9 flush masks
    {4'd9,  1'b1, 1'b0, 2'd3, 16'h0000, 1'b1, 2'd3, 32'h0000_0000}, // R9 K cleared
    {4'd9,  1'b1, 1'b1, 2'd0, 16'hDBFF, 1'b0, 2'd0, 32'h0},         // R9 flush beats prefix
    {4'd9,  1'b1, 1'b0, 2'd0, 16'h0001, 1'b1, 2'd1, 32'h0000_0001}  // R9 prefix not loaded
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush;
  logic          ivalid;
  logic [15:0]   insn;
  logic [1:0]    cls;
  logic [DW-1:0] rdata;
  logic [4:0]    raddr;
  logic [DW-1:0] operand;
  logic [1:0]    mode;
  logic          opv;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rdata = 32'hA5A5_0000 | {27'd0, raddr};

  pfx_opnd_former #(.DATA_W(DW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush),
    .insn_valid_i (ivalid),
    .insn_i       (insn),
    .op_class_i   (cls),
    .rf_rdata_i   (rdata),
    .rf_raddr_o   (raddr),
    .operand_o    (operand),
    .op_mode_o    (mode),
    .op_valid_o   (opv)
  );

  task automatic check(input int req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, sample a quarter period later, then let the edge pass
  task automatic step(input int req, input logic v, input logic fl, input logic [1:0] c,
                      input logic [15:0] w, input logic eopv, input logic [1:0] emode,
                      input logic [DW-1:0] eop);
    @(negedge clk);
    ivalid = v; flush = fl; cls = c; insn = w;
    #(CLK_PERIOD/4);
    check(req, "op_valid", {31'd0, opv}, {31'd0, eopv});
    if (eopv) begin
      check(req, "mode", {30'd0, mode}, {30'd0, emode});
      check(req, "operand", operand, eop);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ivalid = 1'b0; flush = 1'b0; cls = 2'd0; insn = 16'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ivalid = 1'b0; flush = 1'b0; cls = 2'd0; insn = 16'h0;
    do_reset();

    // R1 reset state: logic class unprefixed reads the register file
    step(1, 1'b1, 1'b0, 2'd2, 16'h0009, 1'b1, 2'd0, 32'hA5A5_0009);
    check(6, "raddr", {27'd0, raddr}, 32'd9); // R6 address field

    for (int i = 0; i < NV; i++) begin
      step(int'(VEC[i][58:55]), VEC[i][54], VEC[i][53], VEC[i][52:51], VEC[i][50:35],
           VEC[i][34], VEC[i][33:32], VEC[i][31:0]);
    end

    // R8: several idle cycles keep a pending prefix for the next instruction
    step(2, 1'b1, 1'b0, 2'd0, 16'hD8C2, 1'b0, 2'd0, 32'h0);   // K=0C2
    for (int j = 0; j < 4; j++)
      step(8, 1'b0, 1'b0, 2'd3, 16'h0000, 1'b0, 2'd0, 32'h0);
    step(8, 1'b1, 1'b0, 2'd3, 16'h0000, 1'b1, 2'd3, 32'h0000_00C2);

    // R1: reset while a prefix is pending discards it
    step(2, 1'b1, 1'b0, 2'd0, 16'hDFFF, 1'b0, 2'd0, 32'h0);
    do_reset();
    step(1, 1'b1, 1'b0, 2'd0, 16'h0015, 1'b1, 2'd1, 32'h0000_0015);
    step(1, 1'b1, 1'b0, 2'd3, 16'h0000, 1'b1, 2'd3, 32'h0000_0000);

    // R5 positive short immediate stays positive; R3 K=0 prefix still selects wide mode
    step(5, 1'b1, 1'b0, 2'd1, 16'h000F, 1'b1, 2'd1, 32'h0000_000F);
    step(2, 1'b1, 1'b0, 2'd0, 16'hD800, 1'b0, 2'd0, 32'h0);
    step(3, 1'b1, 1'b0, 2'd1, 16'h0010, 1'b1, 2'd2, 32'h0000_0010);

    @(negedge clk);
    ivalid = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule